// File: doc/BRIEF.md
# External Clock Bypass Sequencer

This block decides when the IO clock path moves over to an external bypass source, and it adjusts the rates of the derived IO clocks to match. A switch can start in two ways. A hardware requester can ask for it through a four-bit request input. Software can also ask for it through a select field, but that field only counts while a debug-enable input is true. When a switch is triggered, the sequencer raises a request toward the analog clock source and then waits for that source to acknowledge. Once the acknowledge arrives, the block enters a bypassed state and stays there until reset.

On that acknowledge the block can remove one divide-by-2 stage from the derived clocks. The derived clocks are modelled as enable pulses counted from the base IO clock. Whether the stage is removed depends on three things: where the request came from, a software high-speed field, and a scan-mode input that can veto the change at any time. If the hardware requester started the switch, it receives its own acknowledge back. Software has a small configuration register holding the select and high-speed fields. A sticky lock bit guards that register. Once the lock bit is cleared, it stays clear until reset.

Every four-bit control value uses one encoding: true is 4'b0110 and false is 4'b1001. Any other code is read as false.

Top module: `xclk_bypass_seq`

## Requirements
- R1: After reset the outbound request and the hardware acknowledge read false (4'b1001), both configuration fields read 4'b1001, the write-enable reads 1, and the dividers run unstepped.
- R2: While idle, a hardware request equal to 4'b0110 drives the outbound request to 4'b0110 after the next clock edge; the codes 4'b0000, 4'b1111 and 4'b1001 start nothing.
- R3: A stored select field equal to 4'b0110 triggers the switch only while the debug-enable input equals 4'b0110; a select written in some cycle is used from the following edge on.
- R4: Writes to the select and high-speed fields take effect only while the write-enable bit is 1; a lock pulse clears that bit for good until reset, and later writes leave the readback unchanged.
- R5: Once raised, the outbound request stays true until reset. An acknowledge is taken only after one full cycle in the request state, so an acknowledge first seen on the edge right after the trigger completes on the following edge. Acknowledge codes other than 4'b0110 never complete.
- R6: For a hardware-started switch, the acknowledge makes the dividers stepped: bit 0 (div2) pulses every cycle and bit 1 (div4) pulses every other cycle.
- R7: For a software-started switch, the dividers become stepped only if the high-speed field equals 4'b0110 on the acknowledge edge.
- R8: The hardware acknowledge output turns 4'b0110 right after the accepting edge when the switch was hardware-started, and stays 4'b1001 for a software-started switch.
- R9: While scan mode equals 4'b0110, the dividers run unstepped even when bypassed. When scan mode leaves that value, the stepping decided at the acknowledge applies again.
- R10: Let c count the clock edges since reset release. Unstepped, div2 pulses when c mod 2 = 1 and div4 when c mod 4 = 3. Stepped, div2 is always high and div4 pulses when c mod 2 = 1.
- R11: When the hardware and software triggers occur on the same edge, the switch counts as hardware-started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base IO clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_byp_req_i | input | 4 | Hardware bypass request, 4'b0110 = true |
| dbg_en_i | input | 4 | Debug enable that gates the software trigger |
| scan_mode_i | input | 4 | Scan mode; true vetoes divider stepping |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 4 | Select value to write |
| cfg_hispeed_i | input | 4 | High-speed value to write |
| cfg_lock_i | input | 1 | Pulse that clears the write-enable bit |
| cfg_sel_o | output | 4 | Stored select field |
| cfg_hispeed_o | output | 4 | Stored high-speed field |
| cfg_wen_o | output | 1 | Write-enable bit |
| src_byp_req_o | output | 4 | Request to the analog clock source |
| src_byp_ack_i | input | 4 | Acknowledge from the analog clock source |
| hw_byp_ack_o | output | 4 | Acknowledge back to the hardware requester |
| div_en_o | output | NUM_DIV | Divider enable pulses; bit 0 is div2, bit 1 is div4 |

## Verification
The bench targets codes that are close to true but not equal to it, on the request, debug-enable and acknowledge inputs. A design that tests only one bit would start, or finish, a switch it should ignore. It drives the acknowledge in the very cycle the request appears and checks that completion comes one edge later. It writes the select field and raises debug-enable on the same edge, which exposes a design that treats the write as already in effect. It also makes both triggers fire together, sets scan mode on and off after bypass, and clears the lock before writing. Those cases catch a lost hardware origin, a scan veto that is latched instead of live, and a lock that does not hold.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    localparam int unsigned MuBiW = 4;

    typedef logic [MuBiW-1:0] mubi_t;

    localparam mubi_t MuTrue  = 4'b0110;
    localparam mubi_t MuFalse = 4'b1001;

    typedef enum logic [1:0] {
        StIdle,
        StReq,
        StWaitAck,
        StBypassed
    } seq_state_e;

    // Only the exact true code counts as true.
    function automatic logic mu_is_true(mubi_t v);
        return v == MuTrue;
    endfunction

    function automatic mubi_t mu_from_bool(logic b);
        return b ? MuTrue : MuFalse;
    endfunction

endpackage

// File: rtl/xbs_cfg_regs.sv
module xbs_cfg_regs
    import xbs_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  wr_i,
    input  mubi_t sel_i,
    input  mubi_t hispeed_i,
    input  logic  lock_i,
    output mubi_t sel_o,
    output mubi_t hispeed_o,
    output logic  wen_o
);

    typedef struct packed {
        mubi_t sel;
        mubi_t hispeed;
        logic  wen;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i && cfg_q.wen) begin
            cfg_d.sel     = sel_i;
            cfg_d.hispeed = hispeed_i;
        end
        // The lock only ever clears; nothing sets it again but reset.
        if (lock_i) begin
            cfg_d.wen = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '{sel: MuFalse, hispeed: MuFalse, wen: 1'b1};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign sel_o     = cfg_q.sel;
    assign hispeed_o = cfg_q.hispeed;
    assign wen_o     = cfg_q.wen;

endmodule

// File: rtl/xbs_seq_fsm.sv
module xbs_seq_fsm
    import xbs_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  hw_trig_i,
    input  logic  sw_trig_i,
    input  logic  hispeed_i,
    input  logic  ack_i,
    output logic  req_active_o,
    output logic  hw_done_o,
    output logic  step_grant_o
);

    typedef struct packed {
        seq_state_e state;
        logic       from_hw;
        logic       step;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            StIdle: begin
                if (hw_trig_i || sw_trig_i) begin
                    seq_d.state   = StReq;
                    // Hardware origin wins when both fire together.
                    seq_d.from_hw = hw_trig_i;
                end
            end
            StReq: begin
                seq_d.state = StWaitAck;
            end
            StWaitAck: begin
                if (ack_i) begin
                    seq_d.state = StBypassed;
                    seq_d.step  = seq_q.from_hw || hispeed_i;
                end
            end
            StBypassed: begin
                seq_d.state = StBypassed;
            end
            default: begin
                seq_d.state = StIdle;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: StIdle, from_hw: 1'b0, step: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_active_o = (seq_q.state != StIdle);
    assign hw_done_o    = (seq_q.state == StBypassed) && seq_q.from_hw;
    assign step_grant_o = (seq_q.state == StBypassed) && seq_q.step;

endmodule

// File: rtl/xbs_div_gen.sv
module xbs_div_gen #(
    parameter int unsigned NUM_DIV = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               step_i,
    output logic [NUM_DIV-1:0] div_en_o
);

    localparam int unsigned CntW = NUM_DIV;

    typedef struct packed {
        logic [CntW-1:0] cnt;
    } div_t;

    div_t div_d, div_q;

    always_comb begin
        div_d     = div_q;
        div_d.cnt = div_q.cnt + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '{cnt: '0};
        end else begin
            div_q <= div_d;
        end
    end

    // Divider g divides by 2^(g+1) unstepped and by 2^g when stepped.
    for (genvar g = 0; g < NUM_DIV; g++) begin : g_div
        logic full_hit;
        logic step_hit;
        assign full_hit = &div_q.cnt[g:0];
        if (g == 0) begin : g_base
            assign step_hit = 1'b1;
        end else begin : g_upper
            assign step_hit = &div_q.cnt[g-1:0];
        end
        assign div_en_o[g] = step_i ? step_hit : full_hit;
    end

endmodule

// File: rtl/xclk_bypass_seq.sv
module xclk_bypass_seq
    import xbs_pkg::*;
#(
    parameter int unsigned NUM_DIV = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [3:0]         hw_byp_req_i,
    input  logic [3:0]         dbg_en_i,
    input  logic [3:0]         scan_mode_i,
    input  logic               cfg_wr_i,
    input  logic [3:0]         cfg_sel_i,
    input  logic [3:0]         cfg_hispeed_i,
    input  logic               cfg_lock_i,
    output logic [3:0]         cfg_sel_o,
    output logic [3:0]         cfg_hispeed_o,
    output logic               cfg_wen_o,
    output logic [3:0]         src_byp_req_o,
    input  logic [3:0]         src_byp_ack_i,
    output logic [3:0]         hw_byp_ack_o,
    output logic [NUM_DIV-1:0] div_en_o
);

    mubi_t sel_q;
    mubi_t hispeed_q;
    logic  req_active;
    logic  hw_done;
    logic  step_grant;
    logic  step_live;

    xbs_cfg_regs u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (cfg_wr_i),
        .sel_i     (cfg_sel_i),
        .hispeed_i (cfg_hispeed_i),
        .lock_i    (cfg_lock_i),
        .sel_o     (sel_q),
        .hispeed_o (hispeed_q),
        .wen_o     (cfg_wen_o)
    );

    xbs_seq_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .hw_trig_i    (mu_is_true(hw_byp_req_i)),
        .sw_trig_i    (mu_is_true(sel_q) && mu_is_true(dbg_en_i)),
        .hispeed_i    (mu_is_true(hispeed_q)),
        .ack_i        (mu_is_true(src_byp_ack_i)),
        .req_active_o (req_active),
        .hw_done_o    (hw_done),
        .step_grant_o (step_grant)
    );

    // Scan veto is applied live, on top of the latched grant.
    assign step_live = step_grant && !mu_is_true(scan_mode_i);

    xbs_div_gen #(
        .NUM_DIV (NUM_DIV)
    ) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .step_i   (step_live),
        .div_en_o (div_en_o)
    );

    assign cfg_sel_o     = sel_q;
    assign cfg_hispeed_o = hispeed_q;
    assign src_byp_req_o = mu_from_bool(req_active);
    assign hw_byp_ack_o  = mu_from_bool(hw_done);

endmodule

// File: rtl/xclk_bypass_seq_chk.sv
module xclk_bypass_seq_chk #(
    parameter int unsigned NUM_DIV = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [3:0]         hw_byp_req_i,
    input logic [3:0]         scan_mode_i,
    input logic [3:0]         cfg_sel_o,
    input logic [3:0]         cfg_hispeed_o,
    input logic               cfg_wen_o,
    input logic [3:0]         src_byp_req_o,
    input logic [3:0]         hw_byp_ack_o,
    input logic [NUM_DIV-1:0] div_en_o
);

    localparam logic [3:0] T = 4'b0110;

    a_r2_hw_trigger: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_byp_req_o != T && hw_byp_req_i == T) |=> src_byp_req_o == T);

    a_r5_req_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_byp_req_o == T |=> src_byp_req_o == T);

    a_r4_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_wen_o |=> !cfg_wen_o);

    a_r4_locked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_wen_o |=> ($stable(cfg_sel_o) && $stable(cfg_hispeed_o)));

    a_r8_ack_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_byp_ack_o == T |-> src_byp_req_o == T);

    a_r8_ack_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hw_byp_ack_o == T |=> hw_byp_ack_o == T);

    a_r6_hw_stepped: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hw_byp_ack_o == T && scan_mode_i != T) |-> div_en_o[0]);

    a_r9_scan_veto: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scan_mode_i == T && $past(scan_mode_i) == T)
            |-> !(div_en_o[0] && $past(div_en_o[0])));

    for (genvar g = 1; g < NUM_DIV; g++) begin : g_nest
        a_r10_nested: assert property (@(posedge clk_i) disable iff (!rst_ni)
            div_en_o[g] |-> div_en_o[g-1]);
    end

endmodule

bind xclk_bypass_seq xclk_bypass_seq_chk #(
    .NUM_DIV (NUM_DIV)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hw_byp_req_i  (hw_byp_req_i),
    .scan_mode_i   (scan_mode_i),
    .cfg_sel_o     (cfg_sel_o),
    .cfg_hispeed_o (cfg_hispeed_o),
    .cfg_wen_o     (cfg_wen_o),
    .src_byp_req_o (src_byp_req_o),
    .hw_byp_ack_o  (hw_byp_ack_o),
    .div_en_o      (div_en_o)
);

// File: tb/xclk_bypass_seq_test.sv
module xclk_bypass_seq_test;

    localparam logic [3:0] T = 4'b0110;
    localparam logic [3:0] F = 4'b1001;

    localparam int SIG_REQ  = 0;
    localparam int SIG_HACK = 1;
    localparam int SIG_SEL  = 2;
    localparam int SIG_HS   = 3;
    localparam int SIG_WEN  = 4;
    localparam int SIG_DIV  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hw_req = F;
    logic [3:0] dbg_en = F;
    logic [3:0] scan = F;
    logic       wr = 1'b0;
    logic [3:0] wsel = F;
    logic [3:0] whs = F;
    logic       lock = 1'b0;
    logic [3:0] sel_rb;
    logic [3:0] hs_rb;
    logic       wen_rb;
    logic [3:0] src_req;
    logic [3:0] src_ack = F;
    logic [3:0] hw_ack;
    logic [1:0] div_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 0;

    typedef struct {
        int         sig;
        logic [3:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    xclk_bypass_seq uut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .hw_byp_req_i  (hw_req),
        .dbg_en_i      (dbg_en),
        .scan_mode_i   (scan),
        .cfg_wr_i      (wr),
        .cfg_sel_i     (wsel),
        .cfg_hispeed_i (whs),
        .cfg_lock_i    (lock),
        .cfg_sel_o     (sel_rb),
        .cfg_hispeed_o (hs_rb),
        .cfg_wen_o     (wen_rb),
        .src_byp_req_o (src_req),
        .src_byp_ack_i (src_ack),
        .hw_byp_ack_o  (hw_ack),
        .div_en_o      (div_en)
    );

    function automatic logic [1:0] div_model(int c, logic stepped);
        logic [1:0] r;
        if (stepped) begin
            r[0] = 1'b1;
            r[1] = (c % 2) == 1;
        end else begin
            r[0] = (c % 2) == 1;
            r[1] = (c % 4) == 3;
        end
        return r;
    endfunction

    // Monitor: after each edge, pop the queued expectations and compare.
    always @(posedge clk) begin
        if (!rst_n) cyc = 0;
        else        cyc = cyc + 1;
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [3:0] act;
            logic [3:0] exp;
            it  = sb_q.pop_front();
            exp = it.exp;
            case (it.sig)
                SIG_REQ:  act = src_req;
                SIG_HACK: act = hw_ack;
                SIG_SEL:  act = sel_rb;
                SIG_HS:   act = hs_rb;
                SIG_WEN:  act = {3'b000, wen_rb};
                default: begin
                    act = {2'b00, div_en};
                    exp = {2'b00, div_model(cyc, it.exp[0])};
                end
            endcase
            n_checks++;
            if (act !== exp) begin
                n_fail++;
                $display("FAIL %s: signal %0d actual %b expected %b (cycle %0d)",
                         it.tag, it.sig, act, exp, cyc);
            end
        end
    end

    // Queue an expectation for the outputs after the next clock edge.
    task automatic expect_sig(int sig, logic [3:0] exp, string tag);
        item_t it;
        it.sig = sig;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        hw_req  = F;
        dbg_en  = F;
        scan    = F;
        wr      = 1'b0;
        wsel    = F;
        whs     = F;
        lock    = 1'b0;
        src_ack = F;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : driver
        // ---- R1 reset state, R10 unstepped pattern
        do_reset();
        expect_sig(SIG_REQ, F, "R1");
        expect_sig(SIG_HACK, F, "R1");
        expect_sig(SIG_SEL, F, "R1");
        expect_sig(SIG_HS, F, "R1");
        expect_sig(SIG_WEN, 4'd1, "R1");
        for (int i = 0; i < 6; i++) begin
            expect_sig(SIG_DIV, 4'd0, "R10 unstepped");
            tick();
        end

        // ---- R2 near-true hardware codes start nothing
        hw_req = 4'b0000; expect_sig(SIG_REQ, F, "R2 code 0000"); tick();
        hw_req = 4'b1111; expect_sig(SIG_REQ, F, "R2 code 1111"); tick();
        hw_req = F;       expect_sig(SIG_REQ, F, "R2 code 1001"); tick();
        hw_req = T;       expect_sig(SIG_REQ, T, "R2 trigger");   tick();
        hw_req = F;
        for (int i = 0; i < 2; i++) begin
            expect_sig(SIG_REQ, T, "R5 sticky");
            expect_sig(SIG_HACK, F, "R8 before ack");
            expect_sig(SIG_DIV, 4'd0, "R5 waiting");
            tick();
        end
        // R5 non-true acknowledge never completes
        src_ack = 4'b0000;
        for (int i = 0; i < 2; i++) begin
            expect_sig(SIG_HACK, F, "R5 bad ack");
            expect_sig(SIG_DIV, 4'd0, "R5 bad ack");
            tick();
        end
        src_ack = T;
        expect_sig(SIG_HACK, T, "R8 hw ack");
        expect_sig(SIG_DIV, 4'd1, "R6 stepped");
        tick();
        src_ack = F;
        for (int i = 0; i < 4; i++) begin
            expect_sig(SIG_DIV, 4'd1, "R6 R10 stepped");
            expect_sig(SIG_REQ, T, "R5 bypassed");
            tick();
        end
        // R9 live scan veto
        scan = T;
        for (int i = 0; i < 4; i++) begin
            expect_sig(SIG_DIV, 4'd0, "R9 veto");
            tick();
        end
        scan = F;
        for (int i = 0; i < 3; i++) begin
            expect_sig(SIG_DIV, 4'd1, "R9 release");
            tick();
        end

        // ---- R9 scan true at acknowledge time, hardware origin
        do_reset();
        hw_req = T; expect_sig(SIG_REQ, T, "R2"); tick();
        hw_req = F; scan = T; tick();
        src_ack = T;
        expect_sig(SIG_HACK, T, "R8");
        expect_sig(SIG_DIV, 4'd0, "R9 veto at ack");
        tick();
        src_ack = F;
        expect_sig(SIG_DIV, 4'd0, "R9 veto held"); tick();
        scan = F;
        expect_sig(SIG_DIV, 4'd1, "R9 grant kept"); tick();

        // ---- R3 software trigger needs debug enable; R7 no high speed
        do_reset();
        wr = 1'b1; wsel = T; whs = F;
        expect_sig(SIG_SEL, T, "R3 write"); tick();
        wr = 1'b0;
        expect_sig(SIG_REQ, F, "R3 no debug"); tick();
        dbg_en = 4'b1110;
        expect_sig(SIG_REQ, F, "R3 debug code 1110"); tick();
        dbg_en = T;
        expect_sig(SIG_REQ, T, "R3 debug true"); tick();
        // R5 acknowledge in the cycle the request shows
        src_ack = T;
        expect_sig(SIG_HACK, F, "R5 early ack");
        expect_sig(SIG_DIV, 4'd0, "R5 early ack"); tick();
        expect_sig(SIG_HACK, F, "R8 sw origin");
        expect_sig(SIG_DIV, 4'd0, "R7 no high speed"); tick();
        src_ack = F;
        expect_sig(SIG_DIV, 4'd0, "R7 no high speed"); tick();

        // ---- R3 write and debug on the same edge; R7 high speed
        do_reset();
        wr = 1'b1; wsel = T; whs = T; dbg_en = T;
        expect_sig(SIG_REQ, F, "R3 write not yet used"); tick();
        wr = 1'b0;
        expect_sig(SIG_REQ, T, "R3 trigger next edge"); tick();
        src_ack = T; tick();
        expect_sig(SIG_DIV, 4'd1, "R7 high speed");
        expect_sig(SIG_HACK, F, "R8 sw origin"); tick();
        src_ack = F;
        expect_sig(SIG_DIV, 4'd1, "R7 high speed"); tick();

        // ---- R4 lock
        do_reset();
        wr = 1'b1; wsel = F; whs = T;
        expect_sig(SIG_HS, T, "R4 open write"); tick();
        wr = 1'b0; lock = 1'b1;
        expect_sig(SIG_WEN, 4'd0, "R4 lock"); tick();
        lock = 1'b0; wr = 1'b1; wsel = T; whs = F; dbg_en = T;
        expect_sig(SIG_SEL, F, "R4 locked sel"); tick();
        wr = 1'b0;
        expect_sig(SIG_HS, T, "R4 locked hs");
        expect_sig(SIG_WEN, 4'd0, "R4 lock sticky");
        expect_sig(SIG_REQ, F, "R4 no trigger"); tick();

        // ---- R11 both triggers on one edge
        do_reset();
        wr = 1'b1; wsel = T; whs = F; dbg_en = F; tick();
        wr = 1'b0; dbg_en = T; hw_req = T;
        expect_sig(SIG_REQ, T, "R11 trigger"); tick();
        hw_req = F; tick();
        src_ack = T;
        expect_sig(SIG_HACK, T, "R11 hw origin");
        expect_sig(SIG_DIV, 4'd1, "R11 stepped"); tick();
        src_ack = F;
        tick();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule